// File: doc/BRIEF.md
# Pulse-Density Auxiliary DAC Modulator

This block turns an 8-bit control word into a one-bit stream. The proportion of ones in the stream follows the word's value. An external RC low-pass filter averages the stream into an analog control voltage, for example to steer a variable-gain amplifier or a tuner.

The modulator is a first-order error-feedback accumulator. On every clock edge it adds the control word to an 8-bit accumulator. The carry out of that 9-bit sum becomes the next output bit.

A register interface supplies the word through a data bus and a one-cycle write strobe. The written word is used in the same edge that captures it, so a write never waits for a modulation period to finish. A write also leaves the accumulator alone, so the density moves to its new value without a glitch.

A flag-enable input overrides the stream. While it is high, the output sits at a static level equal to bit 7 of the current word. The accumulator keeps running in the background during this time.

Top module: `pulse_density_dac`

## Requirements
- R1: While reset is high, and after reset until the first write, the output is 0. Reset sets the stored word to 0x00 and the accumulator to 0.
- R2: The word is unsigned straight binary. Over any 256 consecutive modulator steps with a constant word N and flag-enable low, the output is 1 on exactly N of them. This gives 0 ones for 0x00 and 255 ones for 0xFF.
- R3: Each clock edge forms the 9-bit sum of the accumulator and the effective word. The accumulator keeps sum bits 7:0. With flag-enable low, the registered output takes sum bit 8.
- R4: At an edge where the write strobe is high, the effective word is the data input. The output after that edge already reflects the new word, and the word is held for later edges.
- R5: A write does not clear or change the accumulator beyond its normal step, so the stream continues from the accumulated error.
- R6: With flag-enable high at an edge, the output after that edge equals bit 7 of the effective word at that edge. This includes a word written at that same edge.
- R7: The accumulator keeps stepping while flag-enable is high. When flag-enable falls, the carry stream resumes from that running accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wordIn | input | 8 | Control word data |
| wordWr | input | 1 | Write strobe for wordIn |
| flagEn | input | 1 | Static-level override enable |
| pdmOut | output | 1 | Registered one-bit modulator output |

## Verification
Every result is due exactly one rising edge after the inputs that produce it. This covers a write, a flag change, a reset and an ordinary step. The bench drives inputs on the falling edge and compares the output 2 ns after the next rising edge against a per-step expectation computed from R3, R4, R6 and R7. Density results are counted over the 256 outputs that follow the edges from the write edge onward, so the write edge itself is the first of the window.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  // strobes from word control to the accumulator datapath
  typedef struct packed {
    logic forceMode;  // hold output at a static level
    logic forceBit;   // level to hold
  } pdm_ctrl_t;
endpackage

// File: rtl/pdm_ctrl.sv
module pdm_ctrl
  import pdm_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordWr,
  input  logic              flagEn,
  output logic [WORD_W-1:0] effWord,
  output pdm_ctrl_t         ctrl
);
  localparam int MSB = WORD_W - 1;

  logic [WORD_W-1:0] wordReg;

  always_ff @(posedge clk) begin
    if (rst)         wordReg <= '0;
    else if (wordWr) wordReg <= wordIn;
  end

  // a write is used in the same edge that stores it
  always_comb begin
    effWord        = wordWr ? wordIn : wordReg;
    ctrl.forceMode = flagEn;
    ctrl.forceBit  = effWord[MSB];
  end
endmodule

// File: rtl/pdm_datapath.sv
module pdm_datapath
  import pdm_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] effWord,
  input  pdm_ctrl_t         ctrl,
  output logic              pdmOut
);
  localparam int SUM_W = WORD_W + 1;

  logic [WORD_W-1:0] acc;
  logic [SUM_W-1:0]  sum;

  assign sum = {1'b0, acc} + {1'b0, effWord};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      pdmOut <= 1'b0;
    end else begin
      acc    <= sum[WORD_W-1:0];
      pdmOut <= ctrl.forceMode ? ctrl.forceBit : sum[SUM_W-1];
    end
  end
endmodule

// File: rtl/pulse_density_dac.sv
module pulse_density_dac
  import pdm_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              wordWr,
  input  logic              flagEn,
  output logic              pdmOut
);
  logic [WORD_W-1:0] effWord;
  pdm_ctrl_t         ctrl;

  pdm_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst(rst), .wordIn(wordIn), .wordWr(wordWr),
    .flagEn(flagEn), .effWord(effWord), .ctrl(ctrl)
  );

  pdm_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst(rst), .effWord(effWord), .ctrl(ctrl), .pdmOut(pdmOut)
  );
endmodule

// File: rtl/pdm_checker.sv
module pdm_checker #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] wordIn,
  input logic              wordWr,
  input logic              flagEn,
  input logic              pdmOut
);
  localparam int MSB = WORD_W - 1;

  logic [WORD_W-1:0] shadowWord;
  logic [WORD_W-1:0] useWord;
  logic [WORD_W-1:0] prevWord;
  logic              prevFree;

  assign useWord = wordWr ? wordIn : shadowWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadowWord <= '0;
      prevWord   <= '0;
      prevFree   <= 1'b0;
    end else begin
      if (wordWr) shadowWord <= wordIn;
      prevWord <= useWord;
      prevFree <= !flagEn;
    end
  end

  // R1: reset forces the output low
  assert_reset_low_R1: assert property (@(posedge clk) rst |=> !pdmOut);

  // R2: a zero word never produces a one
  assert_zero_word_R2: assert property (@(posedge clk) disable iff (rst)
    (!flagEn && useWord == '0) |=> !pdmOut);

  // R3: a word with its top bit set cannot give two lows in a row
  assert_no_double_low_R3: assert property (@(posedge clk) disable iff (rst)
    (!flagEn && prevFree && useWord[MSB] && useWord == prevWord && !pdmOut)
      |=> pdmOut);

  // R4: a zero written this edge already governs the next output
  assert_write_now_R4: assert property (@(posedge clk) disable iff (rst)
    (wordWr && !flagEn && wordIn == '0) |=> !pdmOut);

  // R6: override shows the top bit of the word in use
  assert_flag_level_R6: assert property (@(posedge clk) disable iff (rst)
    flagEn |=> (pdmOut == $past(useWord[MSB])));
endmodule

bind pulse_density_dac pdm_checker #(.WORD_W(WORD_W)) u_pdm_checker (
  .clk(clk), .rst(rst), .wordIn(wordIn), .wordWr(wordWr),
  .flagEn(flagEn), .pdmOut(pdmOut)
);

// File: tb/test_pulse_density_dac.sv
`timescale 1ns/1ps
module test_pulse_density_dac;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] wordIn = 8'h00;
  logic       wordWr = 1'b0;
  logic       flagEn = 1'b0;
  logic       pdmOut;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] mWord = 8'h00;
  logic [7:0] mAcc  = 8'h00;
  int         ones  = 0;

  always #5 clk = ~clk;

  pulse_density_dac i_pulse_density_dac (
    .clk(clk), .rst(rst), .wordIn(wordIn), .wordWr(wordWr),
    .flagEn(flagEn), .pdmOut(pdmOut)
  );

  function automatic logic [9:0] modelStep(input logic r, input logic wr,
      input logic [7:0] w, input logic fl, input logic [7:0] word,
      input logic [7:0] acc);
    logic [7:0] eff;
    logic [8:0] s;
    if (r) return 10'b0;
    eff = wr ? w : word;
    s   = {1'b0, acc} + {1'b0, eff};
    // {expected output, new accumulator, unused}
    return {(fl ? eff[7] : s[8]), s[7:0], 1'b0};
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pdmOut=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic wr, input logic [7:0] w,
                      input logic fl, input string tag);
    logic [9:0] res;
    @(negedge clk);
    rst = r; wordWr = wr; wordIn = w; flagEn = fl;
    res = modelStep(r, wr, w, fl, mWord, mAcc);
    if (r) mWord = 8'h00;
    else if (wr) mWord = w;
    mAcc = res[8:1];
    @(posedge clk);
    #2;
    if (pdmOut === 1'b1) ones++;
    check(pdmOut, res[9], tag);
  endtask

  task automatic density(input logic [7:0] n);
    ones = 0;
    step(1'b0, 1'b1, n, 1'b0, "R4");
    for (int i = 1; i < 256; i++) step(1'b0, 1'b0, 8'h00, 1'b0, "R3");
    total++;
    if (ones != int'(n)) begin
      bad++;
      $display("FAIL R2: word=%0d ones=%0d expected=%0d", n, ones, n);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset and idle after reset
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'h00, 1'b0, "R1");
    for (int i = 0; i < 300; i++) step(1'b0, 1'b0, 8'h00, 1'b0, "R1");

    // R4/R5: half-scale alternation, rewrite mid-stream keeps accumulator
    step(1'b0, 1'b1, 8'h80, 1'b0, "R4");
    step(1'b0, 1'b0, 8'h00, 1'b0, "R3");
    step(1'b0, 1'b0, 8'h00, 1'b0, "R3");
    step(1'b0, 1'b1, 8'h80, 1'b0, "R5");
    step(1'b0, 1'b0, 8'h00, 1'b0, "R5");
    step(1'b0, 1'b1, 8'h40, 1'b0, "R5");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 8'h00, 1'b0, "R5");

    // R2: exact density for boundary and middle words
    density(8'h00);
    density(8'h01);
    density(8'h80);
    density(8'hFF);
    density(8'h37);

    // R6: static level follows the word's top bit, including same-edge writes
    step(1'b0, 1'b1, 8'h81, 1'b1, "R6");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 8'h00, 1'b1, "R6");
    step(1'b0, 1'b1, 8'h7F, 1'b1, "R6");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 8'h00, 1'b1, "R6");
    // R7: accumulator kept running under the override
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 8'h00, 1'b0, "R7");
    step(1'b0, 1'b1, 8'hC3, 1'b1, "R6");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 8'h00, 1'b1, "R7");
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 8'h00, 1'b0, "R7");

    // R3: random mix of writes, overrides and an occasional reset
    for (int i = 0; i < 3000; i++) begin
      logic wr, fl, r;
      wr = ($urandom % 8) == 0;
      fl = ($urandom % 10) == 0;
      r  = ($urandom % 500) == 0;
      step(r, wr, 8'($urandom), fl, r ? "R1" : "R3");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule